// File: doc/BRIEF.md
# Two-Level Round-Robin Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Up to eight request/grant port pairs arrive as active-low signals. Five of them carry live masters. Ports 5 to 7 are held in reserve and are never granted. A configuration word places each live port into a member slot of one of two round-robin rings.

The upper ring rotates among four slots, named A to D, plus one extra member that stands for the whole lower ring. The lower ring rotates among its own four slots, named W to Z. A lower-ring master therefore gets at most one turn for each trip around the upper ring.

Arbitration only happens while the enable input is high. A new decision is taken on a clock edge when the bus is idle or when the current owner has let go of its request. When nobody is requesting, the grant stays parked on the last owner.

Top module: `dual_ring_arbiter`

## Requirements
- R1: While `rst_n` is low, every bit of `gnt_n` is high. After release, no grant appears until a decision edge finds a mapped requester.
- R2: While `arb_en` is low, every bit of `gnt_n` is high and the remembered owner is dropped. After re-enabling, a grant needs a fresh decision.
- R3: Port p is configured by `map_cfg[4p+3:4p]`:
  - bit 3 = slot used;
  - bit 2 = ring (0 upper, 1 lower);
  - bits 1:0 = member (0..3 → A..D or W..Z).
  Ports whose bit 3 is clear, and reserved ports 5 to 7, are never granted, whatever their request.
- R4: At most one bit of `gnt_n` is low at any time.
- R5: While `bus_idle` is low and the granted port keeps its request low, the grant does not change.
- R6: The upper ring searches in the order A, B, C, D, lower-ring member, wrapping around. The search starts just after the last upper winner. After reset the first member searched is A.
- R7: The lower ring searches W, X, Y, Z, wrapping around, starting after its last winner. After reset the first member searched is W. Its pointer moves only when the lower-ring member wins in the upper ring.
- R8: When no mapped port is requesting, the grant stays with the last owner (parking).
- R9: When several ports map to the same slot, the lowest-numbered of them owns the slot. The others are treated as unmapped.
- R10: A change of `map_cfg` does not disturb a held grant. It is used at the next decision.
- R11: A decision uses the inputs sampled at a rising clock edge, and `gnt_n` shows the new owner just after that edge. Each new grant goes to a port whose request was low at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| arb_en | input | 1 | Arbitration enable; low forces all grants off |
| bus_idle | input | 1 | High when the bus is free for a new decision |
| map_cfg | input | 20 | Per-port slot mapping, 4 bits per live port |
| req_n | input | 8 | Active-low request, one per port |
| gnt_n | output | 8 | Active-low grant, one per port |

## Verification
The bench walks the upper ring through a full lap twice. It looks for a design that lets the lower ring advance on every decision, or on upper-ring wins, which would hand out X where W is due. It drops the owner's request while the bus is busy to catch a design that waits for idle and so holds a stale grant. It also catches a design that ignores idle and re-arbitrates under a busy owner.

Reserved and unmapped ports are driven low throughout. A design that decodes all eight ports would grant them. A design that keeps its owner through a disable would re-grant with no decision.

Two ports are mapped onto one slot to expose a design that lets the higher port win or merges both requests. The mapping is changed under a held grant, with requests chosen so that the old and new mappings give different winners. This exposes a design that remaps on the spot or still uses the old table.

// File: rtl/dra_pkg.sv
package dra_pkg;

  // Width of one per-port mapping field: used bit, ring bit, member index.
  function automatic int unsigned field_width(int unsigned slots);
    return 2 + $clog2(slots);
  endfunction

  // Ring position reached by stepping forward from the last winner.
  function automatic int unsigned ring_next(int unsigned last, int unsigned step,
                                            int unsigned n);
    return (last + step) % n;
  endfunction

  function automatic logic field_used(logic [7:0] f, int unsigned fw);
    return f[fw-1];
  endfunction

  function automatic logic field_low(logic [7:0] f, int unsigned fw);
    return f[fw-2];
  endfunction

  function automatic int unsigned field_slot(logic [7:0] f, int unsigned fw);
    return int'(f) & ((1 << (fw - 2)) - 1);
  endfunction

endpackage

// File: rtl/dra_slot_map.sv
module dra_slot_map
  import dra_pkg::*;
#(
  parameter int NUSED = 5,
  parameter int SLOTS = 4,
  parameter int PW    = 3,
  parameter int FW    = 4
) (
  input  logic [NUSED*FW-1:0]         map_cfg,
  input  logic [NUSED-1:0]            req_n,
  output logic [SLOTS-1:0]            hi_req,
  output logic [SLOTS-1:0]            lo_req,
  output logic [SLOTS-1:0][PW-1:0]    hi_port,
  output logic [SLOTS-1:0][PW-1:0]    lo_port
);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic          hr, lr;
    logic [PW-1:0] hp, lp;

    // Scan from the top port down so that the lowest port claims the slot.
    always_comb begin
      logic [FW-1:0] f;
      hr = 1'b0;
      lr = 1'b0;
      hp = '0;
      lp = '0;
      for (int p = NUSED - 1; p >= 0; p--) begin
        f = map_cfg[p*FW +: FW];
        if (field_used(8'(f), FW) && field_slot(8'(f), FW) == s) begin
          if (field_low(8'(f), FW)) begin
            lr = ~req_n[p];
            lp = PW'(p);
          end else begin
            hr = ~req_n[p];
            hp = PW'(p);
          end
        end
      end
    end

    assign hi_req[s]  = hr;
    assign lo_req[s]  = lr;
    assign hi_port[s] = hp;
    assign lo_port[s] = lp;
  end

endmodule

// File: rtl/dra_rr_ring.sv
module dra_rr_ring
  import dra_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [IW-1:0] win,
  output logic          any
);

  logic [IW-1:0] last_q;

  always_comb begin
    int unsigned idx;
    win = '0;
    any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      idx = ring_next(int'(last_q), k, N);
      if (!any && req[idx]) begin
        any = 1'b1;
        win = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(N - 1);
    end else if (adv && any) begin
      last_q <= win;
    end
  end

endmodule

// File: rtl/dual_ring_arbiter.sv
module dual_ring_arbiter
  import dra_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int NUSED = 5,
  parameter int SLOTS = 4,
  localparam int FW   = field_width(SLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arb_en,
  input  logic                  bus_idle,
  input  logic [NUSED*FW-1:0]   map_cfg,
  input  logic [NPORT-1:0]      req_n,
  output logic [NPORT-1:0]      gnt_n
);

  localparam int PW = $clog2(NPORT);
  localparam int SW = $clog2(SLOTS);
  localparam int HN = SLOTS + 1;
  localparam int HW = $clog2(HN);

  logic [SLOTS-1:0]          hi_req, lo_req;
  logic [SLOTS-1:0][PW-1:0]  hi_port, lo_port;
  logic [HN-1:0]             hi_ring_req;
  logic [HW-1:0]             hi_win;
  logic [SW-1:0]             lo_win;
  logic                      hi_any, lo_any;
  logic                      lo_adv;
  logic                      decide;
  logic                      owner_req;
  logic [PW-1:0]             owner_q, pick_port;
  logic                      owner_vld;

  dra_slot_map #(
    .NUSED(NUSED), .SLOTS(SLOTS), .PW(PW), .FW(FW)
  ) u_map (
    .map_cfg (map_cfg),
    .req_n   (req_n[NUSED-1:0]),
    .hi_req  (hi_req),
    .lo_req  (lo_req),
    .hi_port (hi_port),
    .lo_port (lo_port)
  );

  // The lower ring sits in the upper ring as its last member.
  assign hi_ring_req = {|lo_req, hi_req};

  dra_rr_ring #(.N(HN), .IW(HW)) u_hi_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (hi_ring_req),
    .adv   (decide),
    .win   (hi_win),
    .any   (hi_any)
  );

  dra_rr_ring #(.N(SLOTS), .IW(SW)) u_lo_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (lo_req),
    .adv   (lo_adv),
    .win   (lo_win),
    .any   (lo_any)
  );

  assign owner_req = owner_vld && !req_n[owner_q];
  assign decide    = arb_en && (bus_idle || !owner_req);
  assign lo_adv    = decide && hi_any && lo_any && (hi_win == HW'(SLOTS));

  always_comb begin
    if (hi_win == HW'(SLOTS)) pick_port = lo_port[lo_win];
    else                      pick_port = hi_port[hi_win[SW-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_vld <= 1'b0;
      owner_q   <= '0;
    end else if (!arb_en) begin
      owner_vld <= 1'b0;
    end else if (decide && hi_any) begin
      owner_vld <= 1'b1;
      owner_q   <= pick_port;
    end
  end

  always_comb begin
    gnt_n = '1;
    if (arb_en && owner_vld) gnt_n[owner_q] = 1'b0;
  end

endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int NPORT = 8,
  parameter int NUSED = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arb_en,
  input logic             bus_idle,
  input logic [NPORT-1:0] req_n,
  input logic [NPORT-1:0] gnt_n,
  input logic             decide,
  input logic             hi_any
);

  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~gnt_n));

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_en |-> (&gnt_n));

  p_reserved_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    &gnt_n[NPORT-1:NUSED]);

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && !bus_idle && ((~gnt_n & ~req_n) != '0))
      |=> (!arb_en || $stable(gnt_n)));

  p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && (&req_n[NUSED-1:0]) && !(&gnt_n))
      |=> (!arb_en || $stable(gnt_n)));

  p_new_grant_requested_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((~gnt_n) & $past(gnt_n) & $past(req_n)) == '0);

  p_decision_grants_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && hi_any) |=> (!arb_en || !(&gnt_n)));

endmodule

bind dual_ring_arbiter dra_checker #(.NPORT(NPORT), .NUSED(NUSED)) u_dra_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arb_en   (arb_en),
  .bus_idle (bus_idle),
  .req_n    (req_n),
  .gnt_n    (gnt_n),
  .decide   (decide),
  .hi_any   (hi_any)
);

// File: tb/dual_ring_arbiter_test.sv
`timescale 1ns/1ps
module dual_ring_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        arb_en;
  logic        bus_idle;
  logic [19:0] map_cfg;
  logic [7:0]  req_n;
  logic [7:0]  gnt_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  dual_ring_arbiter uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .arb_en   (arb_en),
    .bus_idle (bus_idle),
    .map_cfg  (map_cfg),
    .req_n    (req_n),
    .gnt_n    (gnt_n)
  );

  // Fields: {arb_en, bus_idle, req_n[7:0], expected gnt_n[7:0]}.
  // Mapping 20'hADC98: p0->A, p1->B, p2->W, p3->X, p4->C. Reserved ports always request.
  localparam int NVEC = 17;
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 8'b0000_0000, 8'hFF},
    {1'b1, 1'b1, 8'b0000_0000, 8'hFE},
    {1'b1, 1'b0, 8'b0000_0000, 8'hFE},
    {1'b1, 1'b1, 8'b0000_0000, 8'hFD},
    {1'b1, 1'b1, 8'b0000_0000, 8'hEF},
    {1'b1, 1'b1, 8'b0000_0000, 8'hFB},
    {1'b1, 1'b1, 8'b0000_0000, 8'hFE},
    {1'b1, 1'b1, 8'b0000_0000, 8'hFD},
    {1'b1, 1'b1, 8'b0000_0000, 8'hEF},
    {1'b1, 1'b1, 8'b0000_0000, 8'hF7},
    {1'b1, 1'b1, 8'b0001_0011, 8'hFB},
    {1'b1, 1'b0, 8'b0001_0111, 8'hF7},
    {1'b1, 1'b1, 8'b0001_1111, 8'hF7},
    {1'b1, 1'b0, 8'b0001_1111, 8'hF7},
    {1'b0, 1'b1, 8'b0000_0000, 8'hFF},
    {1'b1, 1'b1, 8'b0001_1111, 8'hFF},
    {1'b1, 1'b0, 8'b0001_1101, 8'hFD}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 14:         return "R2 disabled";
      1, 3, 4, 6, 7, 8: return "R6 upper ring order";
      2:             return "R5 hold while busy";
      5, 9, 10:      return "R7 lower ring order";
      11:            return "R7 owner drop re-arbitrates";
      12, 13:        return "R8 parking";
      15:            return "R3 reserved never granted";
      default:       return "R2 fresh decision after enable";
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] exp);
    checks++;
    if (gnt_n !== exp) begin
      fails++;
      $display("FAIL %s: gnt_n=%h expected %h", tag, gnt_n, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, gnt_n=%h expected completion", gnt_n);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    arb_en   = 1'b1;
    bus_idle = 1'b1;
    req_n    = 8'h00;
    map_cfg  = 20'hADC98;
    repeat (3) @(negedge clk);
    check("R1 reset holds grants off", 8'hFF);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      {arb_en, bus_idle, req_n} = VEC[i][17:8];
      @(negedge clk);
      check(vec_tag(i), VEC[i][7:0]);
    end

    // R11: the grant moves only after the edge that sees the inputs.
    bus_idle = 1'b1;
    req_n    = 8'b0001_1110;
    #1;
    check("R11 no change before edge", 8'hFD);
    @(negedge clk);
    check("R11 grant after edge", 8'hFE);

    // R10: remap port3 into upper slot D while port0 holds the bus.
    bus_idle = 1'b0;
    req_n    = 8'b0001_0010;
    map_cfg  = 20'hABC98;
    @(negedge clk);
    check("R10 held grant survives remap", 8'hFE);
    bus_idle = 1'b1;
    @(negedge clk);
    check("R10 new map used at decision", 8'hF7);

    // R3: unmapped port is ignored.
    arb_en = 1'b0;
    @(negedge clk);
    check("R2 disable clears grant", 8'hFF);
    arb_en  = 1'b1;
    map_cfg = 20'hAB498;
    req_n   = 8'b0001_1011;
    @(negedge clk);
    check("R3 unmapped port not granted", 8'hFF);
    @(negedge clk);
    check("R3 unmapped port still not granted", 8'hFF);

    // R9: ports 0 and 4 share slot A; port0 owns it.
    map_cfg = 20'h8B498;
    req_n   = 8'b0000_1111;
    @(negedge clk);
    check("R9 higher duplicate ignored", 8'hFF);
    req_n   = 8'b0000_1110;
    @(negedge clk);
    check("R9 lowest duplicate granted", 8'hFE);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule